// File: doc/BRIEF.md
# DRAM Command Reordering Queue

This block sits between request sources and a DRAM controller. It holds a few read and write requests, each with a bank, row, column and tag. Each cycle it offers one of them to the controller. It does not simply issue them in arrival order. It looks past the oldest entry so that a request to an idle bank can go ahead while another bank is still recovering from a row change. It also keeps issuing the same direction, read or write, for as long as it can, which reduces turnaround on the data bus.

The scheduler runs on the controller clock, which is half the memory clock. A small timer per bank models precharge and activate: a bank counts as busy for a fixed number of cycles after it receives a command that opens a different row. Correctness comes first. A request never moves past an older request to the same bank and row when either of the two is a write. An aging counter also guarantees that the oldest request is not bypassed forever. Requests enter and commands leave through valid/ready handshakes, and each issued command keeps its tag.

Top module: `cmdq_top`

## Requirements
- R1: After reset the queue is empty, `reqReady` is 1, `issueValid` is 0, the previous issue direction is taken as read, and the bypass count is zero.
- R2: A request is stored when `reqValid` and `reqReady` are both high at a clock edge. `reqReady` is low exactly when DEPTH entries are held. A request offered while the queue is full is not stored and never appears at the issue port.
- R3: An issued command carries the type, bank, row, column and tag it arrived with. It leaves the queue on an edge where `issueValid` and `issueReady` are both high. The remaining entries keep their relative age order.
- R4: An entry whose bank is busy is not eligible. If the oldest entry's bank is busy, a younger eligible entry to an idle bank is issued first.
- R5: Among eligible entries, the oldest one with the same direction as the last issued command is chosen. If there is none, the oldest eligible entry is chosen. Queued R0, W1, R2, W3 to four idle banks issue as R0, R2, W1, W3 when the last issue was a read.
- R6: An entry is never issued ahead of an older queued entry with the same bank and row when at least one of the two is a write.
- R7: Issuing to a bank whose open row differs from the command's row, or that has no open row, makes that bank busy for BUSY_CYC cycles (default 4). A later command to that bank then issues no earlier than BUSY_CYC+1 cycles afterwards. A command to the already open row starts no busy period.
- R8: Each time a younger entry is issued ahead of the oldest one, the oldest entry's bypass count rises by one. Once AGE_LIMIT bypasses (default 8) have happened, only the oldest entry may issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock (half memory rate) |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Queue can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 3 | Request bank |
| reqRow | input | 14 | Request row |
| reqCol | input | 10 | Request column |
| reqTag | input | 4 | Request tag, returned on issue |
| issueValid | output | 1 | A command is offered to the controller |
| issueReady | input | 1 | Controller takes the command |
| issueWrite | output | 1 | Issued type |
| issueBank | output | 3 | Issued bank |
| issueRow | output | 14 | Issued row |
| issueCol | output | 10 | Issued column |
| issueTag | output | 4 | Issued tag |

## Verification
The bench loads four requests while the controller is stalled, then releases the controller and compares the issue order with sequences worked out by hand.
- Direction grouping: a design that ignores direction would interleave reads and writes.
- Look-ahead: a design without it would stall behind a bank that is still recovering.
- Hazard protection: a design that lets a request pass a conflicting older one to the same bank and row would reorder a read and a write to the same location.
- Full queue: a request offered while full must never show up at the issue port.
- Busy timer: the gap between issues to one bank must be five cycles after a row change and one cycle on a row hit. A timer that is too short, too long or restarted on row hits shows up here.
- Aging: a write is kept behind a continuous stream of reads. It must issue after exactly eight bypasses, not never and not earlier.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
  localparam int BANK_W    = 3;
  localparam int ROW_W     = 14;
  localparam int COL_W     = 10;
  localparam int TAG_W     = 4;
  localparam int MAX_DEPTH = 16;

  typedef struct packed {
    logic             isWrite;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [TAG_W-1:0]  tag;
  } cmd_t;

  // strobes from scheduler to storage
  typedef struct packed {
    logic                 push;
    logic                 pop;
    logic [MAX_DEPTH-1:0] selOh;
  } qCtl_t;
endpackage

// File: rtl/cmdq_store.sv
`timescale 1ns/1ps
module cmdq_store import cmdq_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qCtl_t            ctl,
  input  cmd_t             inCmd,
  output cmd_t             slot [DEPTH],
  output logic [DEPTH-1:0] slotVld,
  output logic [CNT_W-1:0] count,
  output cmd_t             outCmd
);
  cmd_t             nSlot [DEPTH];
  logic [DEPTH-1:0] nVld;
  logic [DEPTH-1:0] shiftEn;
  logic [CNT_W-1:0] wrPos;

  // every slot at or above the removed one takes its upper neighbour
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      acc = acc | ctl.selOh[i];
      shiftEn[i] = acc & ctl.pop;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(slotVld[i]);
  end

  assign wrPos = count - CNT_W'(ctl.pop);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int up;
      up = (i < DEPTH - 1) ? i + 1 : i;
      nSlot[i] = slot[i];
      nVld[i]  = slotVld[i];
      if (shiftEn[i]) begin
        nSlot[i] = slot[up];
        nVld[i]  = (i < DEPTH - 1) ? slotVld[up] : 1'b0;
      end
      if (ctl.push && wrPos == CNT_W'(i)) begin
        nSlot[i] = inCmd;
        nVld[i]  = 1'b1;
      end
    end
  end

  always_comb begin
    outCmd = '0;
    for (int i = 0; i < DEPTH; i++) if (ctl.selOh[i]) outCmd = slot[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      slotVld <= nVld;
      for (int i = 0; i < DEPTH; i++) slot[i] <= nSlot[i];
    end
  end
endmodule

// File: rtl/cmdq_sched.sv
`timescale 1ns/1ps
module cmdq_sched import cmdq_pkg::*; #(
  parameter int DEPTH     = 4,
  parameter int BUSY_CYC  = 4,
  parameter int AGE_LIMIT = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int AGE_W     = $clog2(AGE_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmd_t                 slot [DEPTH],
  input  logic [DEPTH-1:0]     slotVld,
  input  logic [CNT_W-1:0]     count,
  input  cmd_t                 issueCmd,
  input  logic                 reqValid,
  input  logic                 issueReady,
  output logic                 reqReady,
  output logic                 issueValid,
  output qCtl_t                ctl,
  output logic [NUM_BANKS-1:0] bankBusy,
  output logic [AGE_W-1:0]     ageCnt
);
  localparam int BC_W = $clog2(BUSY_CYC + 1);

  logic [BC_W-1:0]      busyCnt [NUM_BANKS];
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [NUM_BANKS-1:0] rowOpen;
  logic                 lastWrite;
  logic [DEPTH-1:0]     hazard, elig, pref, cand, selLocal;
  logic                 forceOld;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
    assign bankBusy[b] = busyCnt[b] != '0;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hazard[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && slotVld[j] && slot[j].bank == slot[i].bank &&
            slot[j].row == slot[i].row && (slot[j].isWrite || slot[i].isWrite))
          hazard[i] = 1'b1;
      elig[i] = slotVld[i] && !bankBusy[slot[i].bank] && !hazard[i];
      pref[i] = elig[i] && (slot[i].isWrite == lastWrite);
    end
  end

  assign forceOld = ageCnt >= AGE_W'(AGE_LIMIT);

  always_comb begin
    if (forceOld)   cand = elig & DEPTH'(1);
    else if (|pref) cand = pref;
    else            cand = elig;
  end

  assign selLocal   = cand & (~cand + DEPTH'(1));
  assign issueValid = |cand;
  assign reqReady   = count < CNT_W'(DEPTH);

  always_comb begin
    ctl       = '0;
    ctl.push  = reqValid && reqReady;
    ctl.pop   = issueValid && issueReady;
    ctl.selOh[DEPTH-1:0] = selLocal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen   <= '0;
      lastWrite <= 1'b0;
      ageCnt    <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        busyCnt[b] <= '0;
        openRow[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (ctl.pop && issueCmd.bank == BANK_W'(b) &&
            (!rowOpen[b] || openRow[b] != issueCmd.row)) begin
          busyCnt[b] <= BC_W'(BUSY_CYC);
          openRow[b] <= issueCmd.row;
          rowOpen[b] <= 1'b1;
        end else if (busyCnt[b] != '0) begin
          busyCnt[b] <= busyCnt[b] - 1'b1;
        end
      end
      if (ctl.pop) begin
        lastWrite <= issueCmd.isWrite;
        if (selLocal[0])    ageCnt <= '0;
        else if (!forceOld) ageCnt <= ageCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdq_top.sv
`timescale 1ns/1ps
module cmdq_top import cmdq_pkg::*; #(
  parameter int DEPTH     = 4,
  parameter int BUSY_CYC  = 4,
  parameter int AGE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              issueValid,
  input  logic              issueReady,
  output logic              issueWrite,
  output logic [BANK_W-1:0] issueBank,
  output logic [ROW_W-1:0]  issueRow,
  output logic [COL_W-1:0]  issueCol,
  output logic [TAG_W-1:0]  issueTag
);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int AGE_W     = $clog2(AGE_LIMIT + 1);

  qCtl_t                ctl;
  cmd_t                 inCmd, outCmd;
  cmd_t                 slot [DEPTH];
  logic [DEPTH-1:0]     slotVld;
  logic [CNT_W-1:0]     count;
  logic [NUM_BANKS-1:0] bankBusy;
  logic [AGE_W-1:0]     ageCnt;

  assign inCmd = '{isWrite: reqWrite, bank: reqBank, row: reqRow, col: reqCol, tag: reqTag};

  cmdq_store #(.DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inCmd(inCmd),
    .slot(slot), .slotVld(slotVld), .count(count), .outCmd(outCmd)
  );

  cmdq_sched #(.DEPTH(DEPTH), .BUSY_CYC(BUSY_CYC), .AGE_LIMIT(AGE_LIMIT)) uSched (
    .clk(clk), .rstN(rstN), .slot(slot), .slotVld(slotVld), .count(count),
    .issueCmd(outCmd), .reqValid(reqValid), .issueReady(issueReady),
    .reqReady(reqReady), .issueValid(issueValid), .ctl(ctl),
    .bankBusy(bankBusy), .ageCnt(ageCnt)
  );

  assign issueWrite = outCmd.isWrite;
  assign issueBank  = outCmd.bank;
  assign issueRow   = outCmd.row;
  assign issueCol   = outCmd.col;
  assign issueTag   = outCmd.tag;
endmodule

// File: rtl/cmdq_checker.sv
`timescale 1ns/1ps
module cmdq_checker import cmdq_pkg::*; #(
  parameter int DEPTH     = 4,
  parameter int AGE_LIMIT = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int AGE_W     = $clog2(AGE_LIMIT + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 issueValid,
  input logic                 issueReady,
  input logic [BANK_W-1:0]    issueBank,
  input logic [CNT_W-1:0]     count,
  input logic [NUM_BANKS-1:0] bankBusy,
  input logic [AGE_W-1:0]     ageCnt,
  input logic [DEPTH-1:0]     selOh
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("count above depth"); // R2

  AST_ACCEPT_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(issueValid && issueReady)) |=> count == $past(count) + 1'b1)
    else $error("accept did not grow queue"); // R2

  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !(reqValid && reqReady)) |=> count == $past(count) - 1'b1)
    else $error("issue did not shrink queue"); // R3

  AST_ISSUE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> count != '0) else $error("issue from empty queue"); // R3

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOh)) else $error("multiple selections"); // R5

  AST_IDLE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !bankBusy[issueBank]) else $error("issue to busy bank"); // R4

  AST_AGE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ageCnt <= AGE_W'(AGE_LIMIT)) else $error("bypass count overflow"); // R8

  AST_AGE_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == AGE_W'(AGE_LIMIT) && issueValid) |-> selOh[0])
    else $error("oldest not forced"); // R8

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(bankBusy[b]) |-> $past(issueValid && issueReady && issueBank == BANK_W'(b)))
      else $error("bank busy without issue"); // R7
  end
endmodule

bind cmdq_top cmdq_checker #(.DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .issueValid(issueValid), .issueReady(issueReady), .issueBank(issueBank),
  .count(count), .bankBusy(bankBusy), .ageCnt(ageCnt), .selOh(ctl.selOh[DEPTH-1:0])
);

// File: tb/tb_cmdq_top.sv
`timescale 1ns/1ps
module tb_cmdq_top;
  import cmdq_pkg::*;
  localparam int BUSY = 4;
  localparam int AGE  = 8;
  localparam int CW   = 1 + BANK_W + ROW_W + COL_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, issueValid, issueReady, issueWrite;
  logic [BANK_W-1:0] reqBank, issueBank;
  logic [ROW_W-1:0]  reqRow, issueRow;
  logic [COL_W-1:0]  reqCol, issueCol;
  logic [TAG_W-1:0]  reqTag, issueTag;

  cmdq_top #(.DEPTH(4), .BUSY_CYC(BUSY), .AGE_LIMIT(AGE)) dut (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  function automatic logic [CW-1:0] mk(bit w, int b, int r, int c);
    return {w, BANK_W'(b), ROW_W'(r), COL_W'(c)};
  endfunction

  // per vector: four commands (tag = slot number) and expected issue order
  localparam logic [CW-1:0] CMDS [20] = '{
    mk(0,0,1,1),  mk(1,1,1,2),  mk(0,2,1,3),  mk(1,3,1,4),   // grouping
    mk(1,0,5,5),  mk(1,0,6,6),  mk(0,1,2,7),  mk(0,2,2,8),   // look-ahead
    mk(0,4,7,9),  mk(1,4,7,10), mk(1,5,1,11), mk(0,6,1,12),  // write behind read
    mk(0,0,1,13), mk(0,0,2,14), mk(0,1,1,15), mk(0,2,1,16),  // busy skipping
    mk(1,6,4,17), mk(0,6,4,18), mk(1,7,4,19), mk(1,1,3,20)   // read behind write
  };
  localparam int ORD [20] = '{0,2,1,3, 0,2,3,1, 2,0,3,1, 0,2,3,1, 0,2,3,1};
  localparam string REQ [5] = '{"R5", "R4", "R6", "R4", "R6"};

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic [CW-1:0] c, int tag);
    @(negedge clk);
    reqValid = 1'b1;
    {reqWrite, reqBank, reqRow, reqCol} = c;
    reqTag = TAG_W'(tag);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got, guard, k, readsBefore;
    int tIss [3];
    bit seenW;
    rstN = 0; reqValid = 0; issueReady = 0; reqWrite = 0;
    reqBank = '0; reqRow = '0; reqCol = '0; reqTag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(issueValid == 1'b0, "R1 idle after reset", issueValid, 0);

    for (int v = 0; v < 5; v++) begin
      for (int t = 0; t < 4; t++) push(CMDS[v*4+t], t);
      @(negedge clk);
      check(reqReady == 1'b0, "R2 ready low when full", reqReady, 0);
      reqValid = 1'b1; {reqWrite, reqBank, reqRow, reqCol} = mk(1,7,999,0); reqTag = 4'd15;
      repeat (2) @(posedge clk);
      #1 reqValid = 1'b0;
      @(negedge clk) issueReady = 1'b1;
      got = 0; guard = 0;
      while (got < 4 && guard < 60) begin
        if (issueValid) begin
          check(int'(issueTag) == ORD[v*4+got], REQ[v], issueTag, ORD[v*4+got]);
          check({issueWrite, issueBank, issueRow, issueCol} == CMDS[v*4+ORD[v*4+got]],
                "R3 fields", {issueWrite, issueBank, issueRow, issueCol}, CMDS[v*4+ORD[v*4+got]]);
          got++;
        end
        @(negedge clk);
        guard++;
      end
      check(got == 4, "R3 all issued", got, 4);
      repeat (8) @(negedge clk);
      check(issueValid == 1'b0, "R2 full-time request dropped", issueValid, 0);
      issueReady = 1'b0;
    end

    // R7: row change opens a busy window, row hit does not
    push(mk(0,2,100,1), 1); push(mk(0,2,100,2), 2); push(mk(0,2,100,3), 3);
    @(negedge clk) issueReady = 1'b1;
    got = 0; guard = 0;
    while (got < 3 && guard < 40) begin
      if (issueValid) begin
        check(int'(issueTag) == got + 1, "R3 same-bank order", issueTag, got + 1);
        tIss[got] = cyc;
        got++;
      end
      @(negedge clk);
      guard++;
    end
    check(tIss[1] - tIss[0] == BUSY + 1, "R7 busy after row change", tIss[1] - tIss[0], BUSY + 1);
    check(tIss[2] - tIss[1] == 1, "R7 no busy on row hit", tIss[2] - tIss[1], 1);
    repeat (8) @(negedge clk);
    issueReady = 1'b0;

    // R8: a write held behind a read stream is forced out after AGE bypasses
    push(mk(1,0,200,0), 0);
    for (int j = 0; j < 3; j++) push(mk(0, 1 + j % 7, 300 + j, j), 1 + j % 15);
    k = 3; readsBefore = 0; seenW = 0; guard = 0;
    @(negedge clk) issueReady = 1'b1;
    while (!seenW && guard < 100) begin
      if (issueValid) begin
        if (issueWrite && issueTag == '0) seenW = 1;
        else readsBefore++;
      end
      if (reqReady && !seenW && k < 30) begin
        reqValid = 1'b1;
        {reqWrite, reqBank, reqRow, reqCol} = mk(0, 1 + k % 7, 300 + k, k);
        reqTag = TAG_W'(1 + k % 15);
        k++;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    reqValid = 1'b0;
    check(seenW, "R8 oldest write issued", seenW, 1);
    check(readsBefore == AGE, "R8 bypasses before forced issue", readsBefore, AGE);
    repeat (40) @(negedge clk);
    check(issueValid == 1'b0, "R3 queue drained", issueValid, 0);
    check(reqReady == 1'b1, "R2 ready when empty", reqReady, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule